// File: doc/BRIEF.md
# Planar Refresh Pixel Serializer

This block sits on the display refresh path behind a four-plane frame buffer. Each fetched 32-bit word holds one byte per plane. Byte k of the word is plane k. In four-plane graphics mode, one word carries eight 4-bit pixel indices. Each pixel index is built by taking the same bit position from every plane, so a pixel is not a contiguous nibble of the word. The block gathers those bits and emits the eight indices one per enabled pixel clock, starting with the leftmost pixel.

Words arrive on a valid/ready load port. The output is a pixel index with a valid flag. A two-state controller runs the block:

- `ST_EMPTY`: no word is held.
  - Transition *load*: a word is accepted, and the controller moves to `ST_SHIFT`.
- `ST_SHIFT`: a word is being emitted.
  - Transition *advance*: an enabled cycle before the eighth pixel. The controller stays in `ST_SHIFT`.
  - Transition *reload*: the eighth pixel leaves while a new word is accepted in the same cycle. The controller stays in `ST_SHIFT`.
  - Transition *drain*: the eighth pixel leaves with no new word. The controller returns to `ST_EMPTY`.

When words arrive continuously, the pixel stream has no gaps.

Top module: `pps_serializer`

## Requirements
- R1: The reset is synchronous and active high. While `rst` is high, and on the first cycle after it falls, `pix_valid` is 0, `pix_index` is 0 and `word_ready` is 1, meaning the block is empty.
- R2: Plane k is bits 8k+7..8k of `word_data`. Bit k of every pixel index comes from plane k, so plane 3 supplies the MSB and plane 0 the LSB.
- R3: Pixel p of a word (p = 0 is leftmost) has bit k equal to `word_data[8k + 7 - p]`. The leftmost pixel is therefore formed from bit 7 of each plane.
- R4: A word is accepted on a rising edge where `word_valid` and `word_ready` are both 1. On each of the following rising edges with `pix_en` = 1, the block presents the next pixel with `pix_valid` = 1, for pixels 0..7 in order. Each word yields exactly eight pixels.
- R5: `word_ready` is 1 when the block is empty. It is also 1 while the eighth pixel is pending and `pix_en` = 1. It is 0 otherwise.
- R6: With `word_valid` and `pix_en` held at 1, the next word is accepted on the same edge that emits the previous word's eighth pixel. `pix_valid` then stays 1 on every cycle across word boundaries.
- R7: On a cycle that follows an edge with `pix_en` = 0, `pix_valid` is 0, `pix_index` keeps its previous value and the pixel position does not advance.
- R8: While no word is loaded, `pix_valid` stays 0 and `pix_index` holds the last pixel emitted.
- R9: `word_valid` and `word_data` are ignored on cycles where `word_ready` is 0. The pixels of the held word continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel advance enable |
| word_valid | input | 1 | Fetched word present |
| word_data | input | 32 | Fetched word; byte k is plane k |
| word_ready | output | 1 | Word accepted on this edge if valid |
| pix_valid | output | 1 | `pix_index` carries a new pixel |
| pix_index | output | 4 | 4-bit pixel index, plane 3 as MSB |

## Verification
Two functions can fall in the same cycle: emitting the eighth pixel of a held word, and loading the next word. Directed runs of back-to-back words with `pix_en` held high provoke this overlap. Long random runs also provoke it, with `word_valid` and `pix_en` toggling so that the eighth pixel sometimes meets an offered word and sometimes a disabled cycle. The bench judges each case against its own queue model in two ways. `word_ready` must match the rule in R5 on that cycle. The following cycle must show pixel 0 of the new word with no gap, or else a drain to the empty state.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int PPS_PLANES       = 4;
    localparam int PPS_PLANE_BITS   = 8;
    localparam int PPS_WORD_W       = PPS_PLANES * PPS_PLANE_BITS;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_SHIFT = 1'b1
    } pps_state_t;
endpackage

// File: rtl/pps_plane_gather.sv
module pps_plane_gather #(
    parameter int PLANES     = 4,
    parameter int PLANE_BITS = 8,
    localparam int WORD_W    = PLANES * PLANE_BITS
) (
    input  logic [WORD_W-1:0]                     word_in,
    output logic [PLANE_BITS-1:0][PLANES-1:0]     pix_out
);
    // Pixel p takes bit (PLANE_BITS-1-p) from each plane; plane k lands in bit k.
    for (genvar gp = 0; gp < PLANE_BITS; gp++) begin : g_pix
        for (genvar gk = 0; gk < PLANES; gk++) begin : g_plane
            assign pix_out[gp][gk] = word_in[gk*PLANE_BITS + (PLANE_BITS-1-gp)];
        end
    end
endmodule

// File: rtl/pps_shift_core.sv
module pps_shift_core
    import pps_pkg::*;
#(
    parameter int PLANES     = 4,
    parameter int PLANE_BITS = 8,
    localparam int POS_W     = (PLANE_BITS > 1) ? $clog2(PLANE_BITS) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              pix_en,
    input  logic                              word_valid,
    input  logic [PLANE_BITS-1:0][PLANES-1:0] gathered,
    output logic                              word_ready,
    output logic                              pix_valid,
    output logic [PLANES-1:0]                 pix_index
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PLANE_BITS - 1);

    pps_state_t                          state, state_nxt;
    logic [POS_W-1:0]                    pos;
    logic [PLANE_BITS-1:0][PLANES-1:0]   pix_buf;
    logic                                accept;
    logic                                at_last;

    assign at_last    = (pos == LAST_POS);
    assign word_ready = (state == ST_EMPTY) || (at_last && pix_en);
    assign accept     = word_valid && word_ready;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (accept) state_nxt = ST_SHIFT;                   // load
            ST_SHIFT: if (pix_en && at_last && !accept) state_nxt = ST_EMPTY; // drain
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix_index <= '0;
            pos       <= '0;
            pix_buf   <= '0;
        end else begin
            pix_valid <= 1'b0;
            if (state == ST_SHIFT && pix_en) begin
                pix_valid <= 1'b1;
                pix_index <= pix_buf[pos];
                pos       <= at_last ? '0 : pos + 1'b1;
            end
            if (accept) begin
                pix_buf <= gathered;
                pos     <= '0;
            end
        end
    end

    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EMPTY) |-> word_ready); // R5
    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_ready) |=> (state == ST_SHIFT && pos == '0)); // R4
    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && pix_en && at_last && word_valid) |=> (state == ST_SHIFT && pix_valid)); // R6
    AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(pix_en)); // R7
    AST_HOLD_IDX: assert property (@(posedge clk) disable iff (rst)
        (!pix_valid && !$past(rst)) |-> $stable(pix_index)); // R8
endmodule

// File: rtl/pps_serializer.sv
module pps_serializer
    import pps_pkg::*;
#(
    parameter int PLANES     = PPS_PLANES,
    parameter int PLANE_BITS = PPS_PLANE_BITS,
    localparam int WORD_W    = PLANES * PLANE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              pix_valid,
    output logic [PLANES-1:0] pix_index
);
    logic [PLANE_BITS-1:0][PLANES-1:0] gathered;

    pps_plane_gather #(.PLANES(PLANES), .PLANE_BITS(PLANE_BITS)) u_gather (
        .word_in (word_data),
        .pix_out (gathered)
    );

    pps_shift_core #(.PLANES(PLANES), .PLANE_BITS(PLANE_BITS)) u_core (
        .clk        (clk),
        .rst        (rst),
        .pix_en     (pix_en),
        .word_valid (word_valid),
        .gathered   (gathered),
        .word_ready (word_ready),
        .pix_valid  (pix_valid),
        .pix_index  (pix_index)
    );
endmodule

// File: tb/pps_serializer_tb.sv
`timescale 1ns/1ps
module pps_serializer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        pix_en;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_ready;
    logic        pix_valid;
    logic [3:0]  pix_index;

    int checks = 0;
    int errors = 0;

    // model state
    logic [31:0] m_word;
    int          m_rem;
    logic        exp_valid;
    logic [3:0]  exp_idx;

    always #2.5 clk = ~clk;

    pps_serializer u_dut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .word_valid(word_valid),
        .word_data(word_data), .word_ready(word_ready),
        .pix_valid(pix_valid), .pix_index(pix_index)
    );

    function automatic logic [3:0] ref_pix(input logic [31:0] w, input int p);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = w[8*k + 7 - p];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: check outputs, drive inputs, check ready, advance model.
    task automatic step(input logic v, input logic [31:0] d, input logic e, input string tag);
        logic exp_rdy;
        @(negedge clk);
        chk({tag, " valid R4 R7 R8"}, 32'(pix_valid), 32'(exp_valid));
        chk({tag, " index R2 R3"}, 32'(pix_index), 32'(exp_idx));
        word_valid = v; word_data = d; pix_en = e;
        #0.5;
        exp_rdy = (m_rem == 0) || (m_rem == 1 && e);
        chk({tag, " ready R5"}, 32'(word_ready), 32'(exp_rdy));
        exp_valid = 1'b0;
        if (e && m_rem > 0) begin
            exp_valid = 1'b1;
            exp_idx   = ref_pix(m_word, 8 - m_rem);
            m_rem--;
        end
        if (v && exp_rdy) begin   // R9: otherwise data ignored
            m_word = d;
            m_rem  = 8;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; pix_en = 1'b0; word_valid = 1'b0; word_data = '0;
        m_rem = 0; m_word = '0; exp_valid = 1'b0; exp_idx = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset valid", 32'(pix_valid), 0);
        chk("R1 reset index", 32'(pix_index), 0);
        chk("R1 reset ready", 32'(word_ready), 1);
        rst = 1'b0;

        // R3: leftmost pixel from bit 7 of each plane
        step(1, 32'h8080_8080, 1, "R3 left");
        for (int i = 0; i < 8; i++) step(0, 32'h0, 1, "R3 left");
        // R2: plane 3 bit 0 only -> pixel 7 = 8; plane 0 bit 7 -> pixel 0 = 1
        step(1, 32'h0100_0080, 1, "R2 planes");
        for (int i = 0; i < 8; i++) step(0, 32'h0, 1, "R2 planes");
        // R8: empty, index holds
        for (int i = 0; i < 4; i++) step(0, 32'hFFFF_FFFF, 1, "R8 empty");
        // R6: back-to-back words
        for (int w = 0; w < 3; w++) begin
            step(1, 32'h1234_5678 + 32'(w * 32'h1111), 1, "R6 b2b");
            for (int i = 0; i < 7; i++) step(1, 32'hDEAD_BEEF, 1, "R6 R9 busy");
        end
        for (int i = 0; i < 9; i++) step(0, 32'h0, 1, "R6 drain");
        // R7: enable low stalls
        step(1, 32'hA5C3_3C5A, 0, "R7 load");
        for (int i = 0; i < 3; i++) step(1, 32'h0F0F_0F0F, 0, "R7 R9 stall");
        for (int i = 0; i < 3; i++) step(1, 32'h0F0F_0F0F, i[0], "R7 mix");
        for (int i = 0; i < 10; i++) step(0, 32'h0, 1, "R7 drain");

        // random mix
        for (int c = 0; c < 4000; c++)
            step(($urandom % 2) == 0, $urandom, ($urandom % 4) != 0, "RND");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule